// File: doc/BRIEF.md
# Automatic Retransmission Controller

This block sits beside a packet radio's transmit path and decides whether a packet goes out again when no acknowledgement comes back. Software programs two 4-bit fields through a small write port. One field sets the gap between tries, in steps of one delay unit. The other sets how many extra tries are allowed. The block then runs each packet on its own: it asks for the first send, and it waits for the end of the transmission. If the ack timer expires, it counts out the gap from the end of that transmission and asks for the next send. This repeats until an acknowledgement arrives or the budget is spent.

The gap is counted in ticks of an external 1 µs timebase. One delay step equals `STEP_TICKS` ticks, which is 250 by default, so the gap runs from 250 µs to 4000 µs. When the budget runs out, a sticky exhausted flag is raised. While that flag is set, nothing is sent, not even a new packet. Software clears the flag by writing a one to bit 0 of the status address.

The control core is a five-state machine:
- **IDLE**: no packet in flight. An accepted start request moves it to TX.
- **TX**: a send has been requested. The transmission-done strobe moves it to ACKWAIT.
- **ACKWAIT**: waiting for the acknowledgement. An ack moves it to IDLE. A timeout moves it to GAP while retries remain, and to HALT when none remain.
- **GAP**: waiting for the gap timer. When the timer expires, the block issues a send request and moves to TX.
- **HALT**: holds until software clears the exhausted flag, then moves to IDLE.

Top module: `arq_retry_ctrl`

## Requirements
- R1: After reset, the configuration byte reads 0x03, which is delay code 0 and retry limit 3. The exhausted flag reads 0, the retry count reads 0, and `send_req` is low.
- R2: A write with `wr_sel`=0 loads `wr_data[7:4]` as the delay code and `wr_data[3:0]` as the retry limit, and these read back on `cfg_rd` in the following cycle. A write with `wr_sel`=1 clears the exhausted flag only when `wr_data[0]` is 1. Writing 0 to that bit leaves the flag unchanged.
- R3: In IDLE, with the exhausted flag clear, `pkt_start` raises `send_req` in the same cycle, and the retry count reads 0 from the next cycle on.
- R4: A retry `send_req` is raised in the cycle in which exactly `STEP_TICKS`×(delay code+1) ticks have been counted since the `tx_done` that ended the previous transmission. The gap timer holds its value while `tick_us` is low.
- R5: An `ack_ok` strobe in ACKWAIT produces a one-cycle `ack_pulse` in the same cycle and clears the retry count on the next edge. No further send follows.
- R6: The retry count increases by exactly one at each retry send.
- R7: An `ack_timeout` in ACKWAIT when the retry count equals the limit sets the exhausted flag on the next edge, with no wait and no further send. This includes a limit of 0, where no retry is made at all.
- R8: While the exhausted flag is set, `send_req` stays low and `pkt_start` is ignored. After the flag is cleared, a new packet can start.
- R9: When `ack_ok` and `ack_timeout` arrive in the same cycle, the acknowledgement wins. A success pulse is produced and no retry or exhaustion follows.
- R10: If a clear write and an exhaustion arrive in the same cycle, the exhausted flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_us | input | 1 | 1 µs timebase strobe |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 = configuration, 1 = status (bit 0 is write-one-to-clear) |
| wr_data | input | 8 | Write data |
| pkt_start | input | 1 | Request to send a new packet |
| tx_done | input | 1 | Strobe marking the end of a transmission |
| ack_ok | input | 1 | Strobe marking a received acknowledgement |
| ack_timeout | input | 1 | Strobe marking an expired ack wait |
| cfg_rd | output | 8 | Configuration readback: delay code in [7:4], retry limit in [3:0] |
| send_req | output | 1 | One-cycle request to start a transmission |
| ack_pulse | output | 1 | One-cycle success pulse |
| exhausted | output | 1 | Sticky retry-budget-exhausted interrupt flag |
| retry_cnt | output | 4 | Retries made for the current packet |

## Verification
The bench builds the block with `STEP_TICKS`=2, so a full 16-step gap is 32 cycles when a tick arrives every cycle. With that setting, the bench can measure every delay code down to the exact cycle. It can also run the whole retry ladder for several limits, up to exhaustion, well inside the run. The field widths stay at their defaults, so every encoding of the delay code and the retry limit is reachable from the bench.

// File: rtl/arq_pkg.sv
package arq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_TX      = 3'd1,
        ST_ACKWAIT = 3'd2,
        ST_GAP     = 3'd3,
        ST_HALT    = 3'd4
    } arq_state_e;
endpackage

// File: rtl/arq_cfg_regs.sv
module arq_cfg_regs #(
    parameter int DLY_W   = 4,
    parameter int CNT_W   = 4,
    parameter int DLY_RST = 0,
    parameter int CNT_RST = 3,
    localparam int DW     = DLY_W + CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [DW-1:0]    wr_data,
    input  logic             exh_set,
    output logic [DLY_W-1:0] dly_q,
    output logic [CNT_W-1:0] lim_q,
    output logic             exh_q
);
    logic cfg_we;
    logic exh_clr;

    assign cfg_we  = wr_en && !wr_sel;
    assign exh_clr = wr_en && wr_sel && wr_data[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dly_q <= DLY_W'(DLY_RST);
            lim_q <= CNT_W'(CNT_RST);
        end else if (cfg_we) begin
            dly_q <= wr_data[DW-1:CNT_W];
            lim_q <= wr_data[CNT_W-1:0];
        end
    end

    // Set has priority over the software clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exh_q <= 1'b0;
        end else if (exh_set) begin
            exh_q <= 1'b1;
        end else if (exh_clr) begin
            exh_q <= 1'b0;
        end
    end
endmodule

// File: rtl/arq_gap_timer.sv
module arq_gap_timer #(
    parameter int DLY_W      = 4,
    parameter int STEP_TICKS = 250,
    localparam int MAXT      = STEP_TICKS * (1 << DLY_W),
    localparam int TW        = $clog2(MAXT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DLY_W-1:0] dly,
    input  logic             tick,
    output logic             done
);
    logic [TW-1:0] cnt;
    logic [TW-1:0] load_val;

    assign load_val = TW'(STEP_TICKS) * (TW'(dly) + TW'(1));
    assign done     = (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (tick && !done) begin
            cnt <= cnt - TW'(1);
        end
    end
endmodule

// File: rtl/arq_fsm.sv
module arq_fsm
    import arq_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_start,
    input  logic             tx_done,
    input  logic             ack_ok,
    input  logic             ack_timeout,
    input  logic             gap_done,
    input  logic             exh_q,
    input  logic [CNT_W-1:0] limit,
    output logic             send_req,
    output logic             ack_pulse,
    output logic             exh_set,
    output logic [CNT_W-1:0] retry_cnt
);
    arq_state_e state, state_nx;
    logic budget_left;

    assign budget_left = (retry_cnt < limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (pkt_start && !exh_q) state_nx = ST_TX;
            ST_TX:      if (tx_done) state_nx = ST_ACKWAIT;
            ST_ACKWAIT: begin
                if (ack_ok)           state_nx = ST_IDLE;
                else if (ack_timeout) state_nx = budget_left ? ST_GAP : ST_HALT;
            end
            ST_GAP:     if (gap_done) state_nx = ST_TX;
            ST_HALT:    if (!exh_q) state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        send_req  = 1'b0;
        ack_pulse = 1'b0;
        exh_set   = 1'b0;
        unique case (state)
            ST_IDLE:    send_req  = pkt_start && !exh_q;
            ST_TX:      ;
            ST_ACKWAIT: begin
                ack_pulse = ack_ok;
                exh_set   = ack_timeout && !ack_ok && !budget_left;
            end
            ST_GAP:     send_req  = gap_done && !exh_q;
            ST_HALT:    ;
            default:    ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            retry_cnt <= '0;
        end else if (state == ST_IDLE && pkt_start && !exh_q) begin
            retry_cnt <= '0;
        end else if (state == ST_ACKWAIT && ack_ok) begin
            retry_cnt <= '0;
        end else if (state == ST_GAP && gap_done) begin
            retry_cnt <= retry_cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/arq_retry_ctrl.sv
module arq_retry_ctrl #(
    parameter int DLY_W      = 4,
    parameter int CNT_W      = 4,
    parameter int STEP_TICKS = 250,
    parameter int DLY_RST    = 0,
    parameter int CNT_RST    = 3,
    localparam int DW        = DLY_W + CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_us,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [DW-1:0]    wr_data,
    input  logic             pkt_start,
    input  logic             tx_done,
    input  logic             ack_ok,
    input  logic             ack_timeout,
    output logic [DW-1:0]    cfg_rd,
    output logic             send_req,
    output logic             ack_pulse,
    output logic             exhausted,
    output logic [CNT_W-1:0] retry_cnt
);
    logic [DLY_W-1:0] dly_q;
    logic [CNT_W-1:0] lim_q;
    logic             exh_q;
    logic             exh_set;
    logic             gap_done;

    arq_cfg_regs #(
        .DLY_W(DLY_W), .CNT_W(CNT_W), .DLY_RST(DLY_RST), .CNT_RST(CNT_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .exh_set(exh_set),
        .dly_q(dly_q), .lim_q(lim_q), .exh_q(exh_q)
    );

    arq_gap_timer #(
        .DLY_W(DLY_W), .STEP_TICKS(STEP_TICKS)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tx_done), .dly(dly_q),
        .tick(tick_us), .done(gap_done)
    );

    arq_fsm #(
        .CNT_W(CNT_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .tx_done(tx_done),
        .ack_ok(ack_ok), .ack_timeout(ack_timeout), .gap_done(gap_done),
        .exh_q(exh_q), .limit(lim_q), .send_req(send_req),
        .ack_pulse(ack_pulse), .exh_set(exh_set), .retry_cnt(retry_cnt)
    );

    assign cfg_rd    = {dly_q, lim_q};
    assign exhausted = exh_q;
endmodule

// File: rtl/arq_retry_ctrl_chk.sv
module arq_retry_ctrl_chk #(
    parameter int DW    = 8,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             wr_sel,
    input logic [DW-1:0]    wr_data,
    input logic             ack_timeout,
    input logic [DW-1:0]    cfg_rd,
    input logic             send_req,
    input logic             ack_pulse,
    input logic             exhausted,
    input logic [CNT_W-1:0] retry_cnt
);
    a_r2_cfg_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel) |=> (cfg_rd == $past(wr_data)));

    a_r2_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (exhausted && wr_en && wr_sel && wr_data[0] && !ack_timeout) |=> !exhausted);

    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (exhausted && !(wr_en && wr_sel && wr_data[0])) |=> exhausted);

    a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        exhausted |-> !send_req);

    a_r5_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        ack_pulse |=> !ack_pulse);

    a_r5_count_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ack_pulse |=> (retry_cnt == '0));
endmodule

bind arq_retry_ctrl arq_retry_ctrl_chk #(.DW(DW), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .ack_timeout(ack_timeout), .cfg_rd(cfg_rd),
    .send_req(send_req), .ack_pulse(ack_pulse), .exhausted(exhausted),
    .retry_cnt(retry_cnt)
);

// File: tb/arq_retry_ctrl_bench.sv
`timescale 1ns/1ps
module arq_retry_ctrl_bench;
    localparam int STEP = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_us = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic       pkt_start = 1'b0;
    logic       tx_done = 1'b0;
    logic       ack_ok = 1'b0;
    logic       ack_timeout = 1'b0;
    logic [7:0] cfg_rd;
    logic       send_req;
    logic       ack_pulse;
    logic       exhausted;
    logic [3:0] retry_cnt;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    arq_retry_ctrl #(.STEP_TICKS(STEP)) u_arq_retry_ctrl (
        .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .pkt_start(pkt_start),
        .tx_done(tx_done), .ack_ok(ack_ok), .ack_timeout(ack_timeout),
        .cfg_rd(cfg_rd), .send_req(send_req), .ack_pulse(ack_pulse),
        .exhausted(exhausted), .retry_cnt(retry_cnt)
    );

    // delay code, retry limit, attempt that gets the ack (15 = never)
    localparam logic [11:0] VEC [6] = '{
        {4'd0,  4'd3, 4'd1},
        {4'd2,  4'd2, 4'd15},
        {4'd0,  4'd0, 4'd15},
        {4'd1,  4'd1, 4'd0},
        {4'd15, 4'd1, 4'd1},
        {4'd3,  4'd4, 4'd15}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic clear_exh();
        wr(1'b0 ^ 1'b1, 8'h00);
        chk(exhausted == 1'b1, "R2 zero write keeps flag", int'(exhausted), 1);
        wr(1'b1, 8'h01);
        chk(exhausted == 1'b0, "R2 w1c clears flag", int'(exhausted), 0);
        @(negedge clk);
    endtask

    task automatic start_pkt();
        pkt_start = 1'b1; #1;
        chk(send_req == 1'b1, "R3 start send", int'(send_req), 1);
        @(negedge clk);
        pkt_start = 1'b0;
        chk(retry_cnt == 4'd0, "R3 count zero", int'(retry_cnt), 0);
    endtask

    task automatic run_pkt(input int d, input int lim, input int ackat);
        int L;
        L = STEP * (d + 1);
        wr(1'b0, 8'((d << 4) | lim));
        chk(cfg_rd == 8'((d << 4) | lim), "R2 cfg readback", int'(cfg_rd), (d << 4) | lim);
        start_pkt();
        for (int a = 0; a < 16; a++) begin
            tx_done = 1'b1;
            @(negedge clk);
            tx_done = 1'b0;
            if (a == ackat) begin
                ack_ok = 1'b1; #1;
                chk(ack_pulse == 1'b1, "R5 ack pulse", int'(ack_pulse), 1);
                @(negedge clk);
                ack_ok = 1'b0;
                chk(ack_pulse == 1'b0, "R5 pulse one cycle", int'(ack_pulse), 0);
                chk(retry_cnt == 4'd0, "R5 count cleared", int'(retry_cnt), 0);
                begin
                    int seen = 0;
                    for (int k = 0; k < L + 4; k++) begin
                        @(negedge clk);
                        if (send_req) seen++;
                    end
                    chk(seen == 0, "R5 no further send", seen, 0);
                end
                break;
            end
            ack_timeout = 1'b1; #1;
            chk(send_req == 1'b0, "R4 no send at timeout", int'(send_req), 0);
            @(negedge clk);
            ack_timeout = 1'b0;
            if (a == lim) begin
                chk(exhausted == 1'b1, "R7 exhausted set", int'(exhausted), 1);
                chk(send_req == 1'b0, "R7 no retry send", int'(send_req), 0);
                chk(retry_cnt == 4'(lim), "R7 count at limit", int'(retry_cnt), lim);
                pkt_start = 1'b1; #1;
                chk(send_req == 1'b0, "R8 start ignored", int'(send_req), 0);
                @(negedge clk);
                pkt_start = 1'b0;
                chk(exhausted == 1'b1, "R8 flag holds", int'(exhausted), 1);
                clear_exh();
                start_pkt();
                chk(1'b1, "R8 restart accepted", 0, 0);
                tx_done = 1'b1; @(negedge clk); tx_done = 1'b0;
                ack_ok = 1'b1; @(negedge clk); ack_ok = 1'b0;
                break;
            end
            begin
                int k = 1;
                while (!send_req && k < 200) begin
                    @(negedge clk);
                    k++;
                end
                chk(k == L, "R4 gap length", k, L);
            end
            @(negedge clk);
            chk(retry_cnt == 4'(a + 1), "R6 count step", int'(retry_cnt), a + 1);
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cfg_rd == 8'h03, "R1 cfg reset", int'(cfg_rd), 3);
        chk(exhausted == 1'b0, "R1 flag reset", int'(exhausted), 0);
        chk(retry_cnt == 4'd0, "R1 count reset", int'(retry_cnt), 0);
        chk(send_req == 1'b0, "R1 no send", int'(send_req), 0);

        foreach (VEC[i]) run_pkt(int'(VEC[i][11:8]), int'(VEC[i][7:4]), int'(VEC[i][3:0]));

        // R4: timer holds without ticks
        wr(1'b0, 8'h01);
        start_pkt();
        tick_us = 1'b0;
        tx_done = 1'b1; @(negedge clk); tx_done = 1'b0;
        ack_timeout = 1'b1; @(negedge clk); ack_timeout = 1'b0;
        begin
            int seen = 0;
            for (int k = 0; k < 10; k++) begin
                @(negedge clk);
                if (send_req) seen++;
            end
            chk(seen == 0, "R4 hold without tick", seen, 0);
        end
        tick_us = 1'b1;
        begin
            int k = 0;
            while (!send_req && k < 200) begin
                @(negedge clk);
                k++;
            end
            chk(k == STEP, "R4 resume after tick", k, STEP);
        end
        @(negedge clk);
        tx_done = 1'b1; @(negedge clk); tx_done = 1'b0;
        ack_ok = 1'b1; @(negedge clk); ack_ok = 1'b0;

        // R9: ack wins over timeout with limit 0
        wr(1'b0, 8'h00);
        start_pkt();
        tx_done = 1'b1; @(negedge clk); tx_done = 1'b0;
        ack_ok = 1'b1; ack_timeout = 1'b1; #1;
        chk(ack_pulse == 1'b1, "R9 ack pulse", int'(ack_pulse), 1);
        @(negedge clk);
        ack_ok = 1'b0; ack_timeout = 1'b0;
        begin
            int seen = 0;
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                if (send_req) seen++;
            end
            chk(seen == 0, "R9 no retry", seen, 0);
        end
        chk(exhausted == 1'b0, "R9 no exhaustion", int'(exhausted), 0);

        // R10: set and clear in same cycle
        start_pkt();
        tx_done = 1'b1; @(negedge clk); tx_done = 1'b0;
        ack_timeout = 1'b1; wr_en = 1'b1; wr_sel = 1'b1; wr_data = 8'h01;
        @(negedge clk);
        ack_timeout = 1'b0; wr_en = 1'b0; wr_data = '0;
        chk(exhausted == 1'b1, "R10 set wins", int'(exhausted), 1);
        clear_exh();

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule